// File: doc/BRIEF.md
# Three-channel timer register front end

This block sits between an 8-bit host bus and three independent down-counter channels. The host selects a register with an active-low chip select and a two-bit address. Addresses 0, 1 and 2 reach the count registers of channels 0, 1 and 2. Address 3 reaches a write-only control register. A control word picks one channel and sets three things for it: the counting mode, binary or BCD counting, and the byte-access pattern used for count writes and count reads.

The block performs the low and high byte steps of each count transfer. When the transfer is complete it gives the channel a single-cycle load strobe and the assembled 16-bit count. In mode 0 a first-byte strobe lets the channel stop counting while the rest of the count is still being written. A latch form of the control word takes a snapshot of a running counter, so the host can read it byte by byte without stopping the count. The counting logic of the channels is outside this block: it receives mode, BCD flag, configuration strobe, load strobe, halt strobe and count value. It returns its live count on `cnt_i`.

All strobes are single-cycle and sampled on the rising clock edge. Outputs are registered and appear one cycle after the access.

Top module: `tmr_host_if`

## Requirements
- R1: While `cs_ni` is high, `wr_i` and `rd_i` have no effect: no strobe, no register change, and `rdata_o` holds.
- R2: A write to address 3 is a control word with these fields:
  - bits [7:6]: channel select.
  - bits [5:4]: access code.
  - bits [3:1]: mode.
  - bit [0]: BCD flag.

  If the channel select is 0 to 2 and the access code is nonzero, the write updates that channel's `mode_o` and `bcd_o` and pulses its `cfg_o` for one cycle. A channel select of 3 is ignored.
- R3: After reset every channel has mode 0, binary counting, access code 3, a count value of 0 and no strobes. `rdata_o` is 0.
- R4: With access code 1 (low byte only), one count write sets the count to {0x00, byte} and pulses `load_o`.
- R5: With access code 2 (high byte only), one count write sets the count to {byte, 0x00} and pulses `load_o`.
- R6: With access code 3, the first count write replaces the low byte and the second replaces the high byte. `load_o` pulses only after the second write.
- R7: With access code 3 and mode 0, the first count write pulses `halt_o` for that channel.
- R8: Count reads follow the channel's access code:
  - code 1 returns the low byte.
  - code 2 returns the high byte.
  - code 3 returns the low byte, then the high byte, alternating.
- R9: A control word with access code 0 copies the selected channel's live count into a holding register and restarts its read sequence. Reads then return the held value until the last byte of the sequence is read, after which reads see the live count again.
- R10: A latch command to a channel that still holds an unread snapshot is ignored.
- R11: A new control word for a channel resets that channel's write and read byte positions and drops any held snapshot.
- R12: A read at address 3 returns 0x00. `rdata_o` changes only on an accepted read.
- R13: Each channel keeps its own byte positions, so accesses to different channels may be interleaved in any order. At most one channel receives `load_o` in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | 2 | Register select: 0-2 count registers, 3 control |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte (ignored when `wr_i` is high) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| cnt_i | input | 3*16 | Live counts of the channels, channel 0 in the low bits |
| mode_o | output | 3*3 | Mode of each channel |
| bcd_o | output | 3 | BCD flag of each channel |
| cfg_o | output | 3 | Control word accepted, one-cycle pulse per channel |
| load_o | output | 3 | Complete count written, one-cycle pulse per channel |
| halt_o | output | 3 | First byte of a two-byte count written in mode 0 |
| load_val_o | output | 3*16 | Count register of each channel |

## Verification
The hardest states to reach are the ones where two sequences overlap. One is a half-read latched snapshot receiving a second latch command. Another is a half-written two-byte count that is interrupted by a new control word or by accesses to other channels. The stimulus creates these states deliberately. While the snapshot is held, the bench changes the live counts every cycle, so a stale or refreshed value shows up. It also interleaves single bytes to different channels between the two halves of a count write. A behavioural model tracks the pointers and snapshot for each channel and is compared with every output on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 16;
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  typedef enum logic [1:0] {
    RL_LATCH = 2'd0,
    RL_LO    = 2'd1,
    RL_HI    = 2'd2,
    RL_BOTH  = 2'd3
  } rl_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           cs_ni,
  input  logic [1:0]     addr_i,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [7:0]     wdata_i,
  output logic [NCH-1:0] ctrl_wr_o,
  output logic [NCH-1:0] latch_o,
  output logic [NCH-1:0] cnt_wr_o,
  output logic [NCH-1:0] cnt_rd_o,
  output logic           rd_en_o,
  output rl_e            ctrl_rl_o,
  output logic [2:0]     ctrl_mode_o,
  output logic           ctrl_bcd_o
);
  logic wr_ok, ctrl_hit;

  assign wr_ok       = !cs_ni && wr_i;
  assign rd_en_o     = !cs_ni && rd_i && !wr_i;   // write wins a collision
  assign ctrl_hit    = wr_ok && (addr_i == CTRL_ADDR);
  assign ctrl_rl_o   = rl_e'(wdata_i[5:4]);
  assign ctrl_mode_o = wdata_i[3:1];
  assign ctrl_bcd_o  = wdata_i[0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_ctrl;
    assign sel_ctrl     = ctrl_hit && (wdata_i[7:6] == 2'(g));
    assign ctrl_wr_o[g] = sel_ctrl && (ctrl_rl_o != RL_LATCH);
    assign latch_o[g]   = sel_ctrl && (ctrl_rl_o == RL_LATCH);
    assign cnt_wr_o[g]  = wr_ok && (addr_i == 2'(g));
    assign cnt_rd_o[g]  = rd_en_o && (addr_i == 2'(g));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             latch_i,
  input  logic             cnt_wr_i,
  input  logic             cnt_rd_i,
  input  rl_e              ctrl_rl_i,
  input  logic [2:0]       ctrl_mode_i,
  input  logic             ctrl_bcd_i,
  input  logic [7:0]       wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [2:0]       mode_o,
  output logic             bcd_o,
  output logic             cfg_o,
  output logic             load_o,
  output logic             halt_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [7:0]       rbyte_o
);
  rl_e              rl_q;
  logic             wptr_q, rptr_q, held_q;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] src;
  logic             hi_sel, rd_last;

  assign src     = held_q ? latch_q : cnt_i;
  assign hi_sel  = (rl_q == RL_HI) || ((rl_q == RL_BOTH) && rptr_q);
  assign rbyte_o = hi_sel ? src[15:8] : src[7:0];
  assign rd_last = (rl_q != RL_BOTH) || rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= '0;
      bcd_o      <= 1'b0;
      rl_q       <= RL_BOTH;
      wptr_q     <= 1'b0;
      rptr_q     <= 1'b0;
      held_q     <= 1'b0;
      latch_q    <= '0;
      load_val_o <= '0;
      cfg_o      <= 1'b0;
      load_o     <= 1'b0;
      halt_o     <= 1'b0;
    end else begin
      cfg_o  <= ctrl_wr_i;
      load_o <= 1'b0;
      halt_o <= 1'b0;
      if (ctrl_wr_i) begin
        mode_o <= ctrl_mode_i;
        bcd_o  <= ctrl_bcd_i;
        rl_q   <= ctrl_rl_i;
        wptr_q <= 1'b0;
        rptr_q <= 1'b0;
        held_q <= 1'b0;
      end else if (latch_i) begin
        if (!held_q) begin
          latch_q <= cnt_i;
          held_q  <= 1'b1;
          rptr_q  <= 1'b0;
        end
      end else if (cnt_wr_i) begin
        unique case (rl_q)
          RL_LO: begin
            load_val_o <= {8'h00, wdata_i};
            load_o     <= 1'b1;
          end
          RL_HI: begin
            load_val_o <= {wdata_i, 8'h00};
            load_o     <= 1'b1;
          end
          default: begin
            if (!wptr_q) begin
              load_val_o[7:0] <= wdata_i;
              wptr_q          <= 1'b1;
              halt_o          <= (mode_o == 3'd0);
            end else begin
              load_val_o[15:8] <= wdata_i;
              wptr_q           <= 1'b0;
              load_o           <= 1'b1;
            end
          end
        endcase
      end else if (cnt_rd_i) begin
        if (rl_q == RL_BOTH) rptr_q <= !rptr_q;
        if (rd_last) held_q <= 1'b0;
      end
    end
  end

  assert_load_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(cnt_wr_i));
  assert_halt_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (mode_o == 3'd0) && $past(cnt_wr_i) && !load_o);
  assert_snapshot_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(held_q) |-> $stable(latch_q));
  assert_cfg_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o |-> $past(ctrl_wr_i));
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_en_i,
  input  logic [1:0]     addr_i,
  input  logic [NCH*8-1:0] rbytes_i,
  output logic [7:0]     rdata_o
);
  logic [7:0] sel;

  always_comb begin
    sel = 8'h00;   // control address reads as zero
    for (int k = 0; k < NCH; k++)
      if (addr_i == 2'(k)) sel = rbytes_i[k*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= 8'h00;
    else if (rd_en_i) rdata_o <= sel;
  end

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rdata_o));
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic [1:0]           addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic [NCH*CNT_W-1:0] cnt_i,
  output logic [NCH*3-1:0]     mode_o,
  output logic [NCH-1:0]       bcd_o,
  output logic [NCH-1:0]       cfg_o,
  output logic [NCH-1:0]       load_o,
  output logic [NCH-1:0]       halt_o,
  output logic [NCH*CNT_W-1:0] load_val_o
);
  logic [NCH-1:0]   ctrl_wr, latch, cnt_wr, cnt_rd;
  logic             rd_en;
  rl_e              ctrl_rl;
  logic [2:0]       ctrl_mode;
  logic             ctrl_bcd;
  logic [NCH*8-1:0] rbytes;

  tmr_decode #(.NCH(NCH)) u_decode (
    .cs_ni(cs_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .ctrl_wr_o(ctrl_wr), .latch_o(latch), .cnt_wr_o(cnt_wr), .cnt_rd_o(cnt_rd),
    .rd_en_o(rd_en), .ctrl_rl_o(ctrl_rl), .ctrl_mode_o(ctrl_mode), .ctrl_bcd_o(ctrl_bcd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tmr_chan_regs u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .ctrl_wr_i(ctrl_wr[g]), .latch_i(latch[g]), .cnt_wr_i(cnt_wr[g]), .cnt_rd_i(cnt_rd[g]),
      .ctrl_rl_i(ctrl_rl), .ctrl_mode_i(ctrl_mode), .ctrl_bcd_i(ctrl_bcd),
      .wdata_i(wdata_i), .cnt_i(cnt_i[g*CNT_W +: CNT_W]),
      .mode_o(mode_o[g*3 +: 3]), .bcd_o(bcd_o[g]), .cfg_o(cfg_o[g]),
      .load_o(load_o[g]), .halt_o(halt_o[g]),
      .load_val_o(load_val_o[g*CNT_W +: CNT_W]), .rbyte_o(rbytes[g*8 +: 8])
    );
  end

  tmr_rd_mux #(.NCH(NCH)) u_rd_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en), .addr_i(addr_i),
    .rbytes_i(rbytes), .rdata_o(rdata_o)
  );

  assert_cs_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> (load_o == '0) && (cfg_o == '0) && (halt_o == '0) && $stable(rdata_o));
  assert_one_load_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));
endmodule

// File: tb/tmr_host_if_tb.sv
module tmr_host_if_tb;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [NCH*16-1:0] cnt_v;
  logic [NCH*3-1:0]  mode_v;
  logic [NCH-1:0]    bcd_v, cfg_v, load_v, halt_v;
  logic [NCH*16-1:0] lval_v;

  always #4 clk = ~clk;

  tmr_host_if #(.NCH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_i(cnt_v), .mode_o(mode_v), .bcd_o(bcd_v),
    .cfg_o(cfg_v), .load_o(load_v), .halt_o(halt_v), .load_val_o(lval_v)
  );

  // behavioural model
  logic [15:0] live [NCH];
  logic [15:0] snap [NCH];
  logic [15:0] creg [NCH];
  int          m_mode [NCH];
  int          m_rl [NCH];
  bit          m_bcd [NCH], m_wp [NCH], m_rp [NCH], m_held [NCH];
  bit          e_cfg [NCH], e_load [NCH], e_halt [NCH];
  logic [7:0]  e_rdata;
  int n_chk = 0, n_fail = 0;
  bit run = 0, done = 0;
  string tag = "R3";

  always_comb
    for (int k = 0; k < NCH; k++) cnt_v[k*16 +: 16] = live[k];

  task automatic check(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic logic [NCH*16-1:0] exp_lval();
    for (int k = 0; k < NCH; k++) exp_lval[k*16 +: 16] = creg[k];
  endfunction
  function automatic logic [NCH*3-1:0] exp_mode();
    for (int k = 0; k < NCH; k++) exp_mode[k*3 +: 3] = 3'(m_mode[k]);
  endfunction
  function automatic logic [NCH-1:0] pack(input bit v [NCH]);
    for (int k = 0; k < NCH; k++) pack[k] = v[k];
  endfunction

  always @(negedge clk) if (run && !done) begin
    check(rdata == e_rdata, {tag, " rdata"}, 64'(rdata), 64'(e_rdata));
    check(mode_v == exp_mode() && bcd_v == pack(m_bcd), {tag, " mode/bcd"},
          64'({mode_v, bcd_v}), 64'({exp_mode(), pack(m_bcd)}));
    check(load_v == pack(e_load) && halt_v == pack(e_halt) && cfg_v == pack(e_cfg),
          {tag, " strobes"}, 64'({cfg_v, load_v, halt_v}),
          64'({pack(e_cfg), pack(e_load), pack(e_halt)}));
    check(lval_v == exp_lval(), {tag, " count"}, 64'(lval_v), 64'(exp_lval()));
  end

  task automatic model(input bit cs, input [1:0] a, input bit w, input bit r, input [7:0] d);
    int ch;
    for (int k = 0; k < NCH; k++) begin e_cfg[k] = 0; e_load[k] = 0; e_halt[k] = 0; end
    if (!cs) return;
    if (w) begin
      if (a == 2'd3) begin
        ch = int'(d[7:6]);
        if (ch < NCH) begin
          if (d[5:4] == 2'd0) begin
            if (!m_held[ch]) begin m_held[ch] = 1; snap[ch] = live[ch]; m_rp[ch] = 0; end
          end else begin
            m_mode[ch] = int'(d[3:1]); m_bcd[ch] = d[0]; m_rl[ch] = int'(d[5:4]);
            m_wp[ch] = 0; m_rp[ch] = 0; m_held[ch] = 0; e_cfg[ch] = 1;
          end
        end
      end else begin
        ch = int'(a);
        if (m_rl[ch] == 1) begin creg[ch] = {8'h00, d}; e_load[ch] = 1; end
        else if (m_rl[ch] == 2) begin creg[ch] = {d, 8'h00}; e_load[ch] = 1; end
        else if (!m_wp[ch]) begin creg[ch][7:0] = d; m_wp[ch] = 1; e_halt[ch] = (m_mode[ch] == 0); end
        else begin creg[ch][15:8] = d; m_wp[ch] = 0; e_load[ch] = 1; end
      end
    end else if (r) begin
      if (a == 2'd3) e_rdata = 8'h00;
      else begin
        logic [15:0] s;
        bit hi;
        ch = int'(a);
        s = m_held[ch] ? snap[ch] : live[ch];
        hi = (m_rl[ch] == 2) || (m_rl[ch] == 3 && m_rp[ch]);
        e_rdata = hi ? s[15:8] : s[7:0];
        if (m_rl[ch] != 3 || m_rp[ch]) m_held[ch] = 0;
        if (m_rl[ch] == 3) m_rp[ch] = !m_rp[ch];
      end
    end
  endtask

  task automatic cyc(input bit cs, input [1:0] a, input bit w, input bit r, input [7:0] d);
    @(negedge clk);
    cs_n = !cs; addr = a; wr = w; rd = r; wdata = d;
    for (int k = 0; k < NCH; k++) live[k] = live[k] - 16'(3 + 5 * k);
    @(posedge clk);
    #1 model(cs, a, w, r, d);
  endtask

  task automatic wrc(input [1:0] a, input [7:0] d); cyc(1, a, 1, 0, d); endtask
  task automatic rdc(input [1:0] a); cyc(1, a, 0, 1, 8'h00); endtask
  task automatic idle(); cyc(0, 2'd0, 0, 0, 8'h00); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin
      live[k] = 16'h8000 + 16'(k * 16'h1111); snap[k] = 0; creg[k] = 0;
      m_mode[k] = 0; m_rl[k] = 3; m_bcd[k] = 0; m_wp[k] = 0; m_rp[k] = 0; m_held[k] = 0;
      e_cfg[k] = 0; e_load[k] = 0; e_halt[k] = 0;
    end
    e_rdata = 8'h00;
    repeat (3) @(negedge clk);
    // R3 reset state
    check(rdata == 8'h00 && mode_v == '0 && bcd_v == '0 && lval_v == '0 &&
          load_v == '0 && cfg_v == '0 && halt_v == '0, "R3 reset", 64'(lval_v), 64'h0);
    rst_n = 1'b1;
    run = 1;
    tag = "R2"; wrc(2'd3, 8'h55); idle(); wrc(2'd3, 8'hFE); idle();
    tag = "R4"; wrc(2'd1, 8'h37); idle();
    tag = "R5"; wrc(2'd3, 8'hA6); wrc(2'd2, 8'h12); idle();
    tag = "R7"; wrc(2'd3, 8'h30); wrc(2'd0, 8'h34);
    tag = "R6"; wrc(2'd0, 8'h12); idle();
    tag = "R13"; wrc(2'd3, 8'h38); wrc(2'd0, 8'hAA); wrc(2'd2, 8'h55); wrc(2'd1, 8'h66);
    wrc(2'd0, 8'hBB); idle();
    tag = "R8"; rdc(2'd0); rdc(2'd0); rdc(2'd1); rdc(2'd2); rdc(2'd0); idle();
    tag = "R9"; wrc(2'd3, 8'h00); idle(); idle(); rdc(2'd0); idle(); rdc(2'd0); rdc(2'd0); rdc(2'd0);
    tag = "R10"; wrc(2'd3, 8'h00); idle(); wrc(2'd3, 8'h00); idle(); rdc(2'd0); wrc(2'd3, 8'h00);
    rdc(2'd0); rdc(2'd0); rdc(2'd0);
    tag = "R9"; wrc(2'd3, 8'h80); idle(); rdc(2'd2); rdc(2'd2);
    tag = "R11"; wrc(2'd3, 8'h32); wrc(2'd0, 8'h11); wrc(2'd3, 8'h32); wrc(2'd0, 8'h22);
    wrc(2'd0, 8'h33); rdc(2'd0); wrc(2'd3, 8'h00); idle(); wrc(2'd3, 8'h34); rdc(2'd0); rdc(2'd0);
    tag = "R1"; cyc(0, 2'd3, 1, 0, 8'h56); cyc(0, 2'd1, 1, 0, 8'h99); cyc(0, 2'd0, 0, 1, 8'h00);
    cyc(0, 2'd3, 1, 0, 8'h00); idle(); rdc(2'd1);
    tag = "R12"; rdc(2'd3); idle(); idle(); cyc(1, 2'd0, 1, 1, 8'h44); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule